// File: doc/BRIEF.md
# PCM Shift Clock and Frame Sync Generator

This block derives the bit clock and the frame marker of a PCM codec link from a faster codec reference clock. A programmable divider sets the shift clock. The divider value is the number of reference cycles in each half of a shift clock period. A frame counter counts rising shift clock edges and raises the sync output for one whole shift clock period at the start of every frame. The frame length is given in shift clocks.

The transmit and receive shifters run in the reference clock domain. The block gives them a one-cycle strobe for each rising edge and for each falling edge of the shift clock. It also gives them the index of the current bit slot in the frame. The shift clock keeps running between the data word and the next sync, so a codec that uses it as its only clock never sees it stop.

Every input and output is a plain level signal; the block carries no data stream, so no valid/ready handshake applies. The divider value and the frame length are plain inputs that are sampled on every cycle. The output clock is not phase-aligned with the reference clock; it is a registered output in the reference domain.

Top module: `pcmclk_gen`

## Requirements
- R1: While `rst_n` is low, or one cycle after `en` was sampled low, `sclk`, `sync`, `rise_stb` and `fall_stb` are 0 and `slot` is 0.
- R2: With `en` high, `sclk` holds each level for exactly D reference cycles, where D = `half_div`. The first high level of `sclk` begins D cycles after `en` is first sampled high.
- R3: A `half_div` value of 0 behaves exactly like a value of 1: `sclk` toggles on every cycle.
- R4: `rise_stb` is 1 in exactly the cycles in which `sclk` has just changed from 0 to 1. `fall_stb` is 1 in exactly the cycles in which it has just changed from 1 to 0. The two are never 1 together.
- R5: `sync` becomes 1 together with the first rising edge of `sclk` after enable. It stays 1 for exactly one shift clock period (2·D reference cycles) and falls together with the next rising edge.
- R6: `slot` is 0 while `sync` is 1. It then increments by one on each rising edge of `sclk`. After slot L−1 it wraps to 0 and raises `sync` again, so sync repeats every L shift clocks (2·D·L reference cycles). L = `frame_len`.
- R7: A `frame_len` value below 17 is treated as 17, so a 16-bit word always fits in a frame.
- R8: `sclk` keeps toggling through the whole frame, after bit 16 as well, for as long as `en` is high.
- R9: If `frame_len` is lowered while `slot` is already at or beyond the new L−1, the next rising edge wraps `slot` to 0 with `sync` high. If `half_div` is lowered while the half-period count is already at or beyond the new D−1, `sclk` toggles on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider and frame counter cleared |
| half_div | input | DIV_W | Reference cycles per shift clock half-period (0 acts as 1) |
| frame_len | input | FRM_W | Shift clocks per frame (below 17 acts as 17) |
| sclk | output | 1 | Shift clock |
| sync | output | 1 | Frame sync, one shift clock wide |
| rise_stb | output | 1 | One-cycle strobe in the cycle `sclk` rose |
| fall_stb | output | 1 | One-cycle strobe in the cycle `sclk` fell |
| slot | output | FRM_W | Index of the current bit slot in the frame |

## Verification
The generator is run with a divider of 2 and a frame of 20, where the half-period and the frame length can be told apart. It is then run with a divider of 0 and a frame of 5, which shows whether both clamps act or whether the raw values leak through. A divider of 3 with a frame of exactly 17 checks that the clamp boundary is not applied off by one. A frame length lowered in the middle of a long frame, and a divider lowered in the middle of a long half-period, check that the wrap tests use "at or beyond" and not equality. Dropping `en` in the middle of a run and raising it again shows whether the first sync after re-enable is placed at the first rising edge.

// File: rtl/pcmclk_pkg.sv
package pcmclk_pkg;
  localparam int WORD_BITS = 16;
  localparam int MIN_FRAME = WORD_BITS + 1;
endpackage

// File: rtl/pcmclk_div.sv
module pcmclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             rise_evt
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] half_cnt;
  logic             sclk_q;
  logic             rise_q;
  logic             fall_q;
  logic             at_end;

  // zero is treated as one
  assign eff_div  = (half_div == '0) ? ONE : half_div;
  // ">=" so that a lowered divider takes effect at once
  assign at_end   = (half_cnt >= (eff_div - ONE));
  assign rise_evt = en && at_end && !sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      sclk_q   <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else if (!en) begin
      half_cnt <= '0;
      sclk_q   <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else if (at_end) begin
      half_cnt <= '0;
      sclk_q   <= ~sclk_q;
      rise_q   <= ~sclk_q;
      fall_q   <= sclk_q;
    end else begin
      half_cnt <= half_cnt + ONE;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end
  end

  assign sclk     = sclk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;
endmodule

// File: rtl/pcmclk_frame.sv
module pcmclk_frame
  import pcmclk_pkg::*;
#(
  parameter int FRM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [FRM_W-1:0] frame_len,
  input  logic             rise_evt,
  output logic             sync,
  output logic [FRM_W-1:0] slot
);
  localparam logic [FRM_W-1:0] LEN_MIN = FRM_W'(MIN_FRAME);
  localparam logic [FRM_W-1:0] ONE     = FRM_W'(1);

  logic [FRM_W-1:0] eff_len;
  logic [FRM_W-1:0] slot_q;
  logic             sync_q;
  logic             started;
  logic             wrap;

  assign eff_len = (frame_len < LEN_MIN) ? LEN_MIN : frame_len;
  // ">=" so that a lowered frame length wraps at the next rising edge
  assign wrap    = !started || (slot_q >= (eff_len - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      sync_q  <= 1'b0;
      started <= 1'b0;
    end else if (!en) begin
      slot_q  <= '0;
      sync_q  <= 1'b0;
      started <= 1'b0;
    end else if (rise_evt) begin
      started <= 1'b1;
      if (wrap) begin
        slot_q <= '0;
        sync_q <= 1'b1;
      end else begin
        slot_q <= slot_q + ONE;
        sync_q <= 1'b0;
      end
    end
  end

  assign sync = sync_q;
  assign slot = slot_q;
endmodule

// File: rtl/pcmclk_gen.sv
module pcmclk_gen
  import pcmclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FRM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  input  logic [FRM_W-1:0] frame_len,
  output logic             sclk,
  output logic             sync,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic [FRM_W-1:0] slot
);
  localparam int FRM_MAX = (1 << FRM_W) - 1;

  logic rise_evt;

  generate
    if (FRM_MAX < MIN_FRAME) begin : g_bad_width
      initial $error("FRM_W too small to hold the minimum frame length");
    end
  endgenerate

  pcmclk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .half_div (half_div),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .rise_evt (rise_evt)
  );

  pcmclk_frame #(.FRM_W(FRM_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .frame_len (frame_len),
    .rise_evt  (rise_evt),
    .sync      (sync),
    .slot      (slot)
  );
endmodule

// File: rtl/pcmclk_chk.sv
module pcmclk_chk #(
  parameter int FRM_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sclk,
  input logic             sync,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic [FRM_W-1:0] slot
);
  assert_disabled_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !sync && !rise_stb && !fall_stb && slot == '0));

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_stb && !fall_stb) |-> $stable(sclk));

  assert_rise_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb == (sclk && !$past(sclk)));

  assert_fall_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb == (!sclk && $past(sclk)));

  assert_no_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  assert_sync_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> rise_stb);

  assert_sync_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync) && en) |-> rise_stb);

  assert_sync_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (slot == '0));

  assert_slot_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && !sync && $past(en)) |-> (slot == FRM_W'($past(slot) + 1'b1)));
endmodule

bind pcmclk_gen pcmclk_chk #(.FRM_W(FRM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .sclk     (sclk),
  .sync     (sync),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb),
  .slot     (slot)
);

// File: tb/pcmclk_gen_bench.sv
`timescale 1ns/1ps
module pcmclk_gen_bench;
  localparam int DIV_W = 8;
  localparam int FRM_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [DIV_W-1:0] half_div = '0;
  logic [FRM_W-1:0] frame_len = '0;
  logic             sclk, sync, rise_stb, fall_stb;
  logic [FRM_W-1:0] slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcmclk_gen #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_pcmclk_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .half_div(half_div), .frame_len(frame_len),
    .sclk(sclk), .sync(sync), .rise_stb(rise_stb), .fall_stb(fall_stb), .slot(slot)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: integer counts of cycles and edges
  int m_cyc = 0, m_lvl = 0, m_sync = 0, m_slot = 0, m_rise = 0, m_fall = 0;
  bit m_run = 0;
  // measurement of sync timing
  int cyc = 0, last_sync_rise = -1, sync_rise_at = -1, exp_period = 0, exp_width = 0;
  bit prev_sync = 0;
  string cur_tag = "R6";

  always @(posedge clk) begin
    int d, l;
    d = (half_div == 0) ? 1 : int'(half_div);
    l = (frame_len < 17) ? 17 : int'(frame_len);
    m_rise = 0; m_fall = 0;
    if (!rst_n || !en) begin
      m_cyc = 0; m_lvl = 0; m_sync = 0; m_slot = 0; m_run = 0;
    end else if (m_cyc + 1 >= d) begin
      m_cyc = 0;
      if (m_lvl == 0) begin
        m_lvl = 1; m_rise = 1;
        if (!m_run || m_slot + 1 >= l) begin m_slot = 0; m_sync = 1; m_run = 1; end
        else begin m_slot++; m_sync = 0; end
      end else begin
        m_lvl = 0; m_fall = 1;
      end
    end else m_cyc++;
    #1;
    cyc++;
    check("R2 sclk", sclk, m_lvl);
    check("R4 rise_stb", rise_stb, m_rise);
    check("R4 fall_stb", fall_stb, m_fall);
    check("R5 sync", sync, m_sync);
    check("R6 slot", slot, m_slot);
    if (sync && !prev_sync) begin
      if (last_sync_rise >= 0 && exp_period > 0)
        check({cur_tag, " sync period"}, cyc - last_sync_rise, exp_period);
      last_sync_rise = cyc;
      sync_rise_at = cyc;
    end
    if (!sync && prev_sync && en && sync_rise_at >= 0 && exp_width > 0)
      check("R5 sync width", cyc - sync_rise_at, exp_width);
    prev_sync = sync;
  end

  task automatic configure(input int dv, input int fl, input string tag);
    @(negedge clk);
    half_div = DIV_W'(dv);
    frame_len = FRM_W'(fl);
    exp_width = 2 * ((dv == 0) ? 1 : dv);
    exp_period = exp_width * ((fl < 17) ? 17 : fl);
    cur_tag = tag;
    last_sync_rise = -1;
    sync_rise_at = -1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cnt;
    run(3);
    // R1: reset state
    check("R1 reset sclk", sclk, 0);
    check("R1 reset sync", sync, 0);
    check("R1 reset slot", slot, 0);
    @(negedge clk); rst_n = 1'b1;
    configure(2, 20, "R6");
    run(4);
    check("R1 disabled sclk", sclk, 0);
    check("R1 disabled sync", sync, 0);
    // R2/R5: first high after D enabled cycles, with sync
    @(negedge clk); en = 1'b1;
    @(negedge clk); check("R2 first half low", sclk, 0);
    @(negedge clk); check("R2 first rise", sclk, 1);
    check("R5 first sync", sync, 1);
    run(400);   // R8: clock keeps running through whole frames
    // R3 and R7: divider 0, short frame
    configure(0, 5, "R7");
    run(300);
    configure(0, 5, "R3");
    run(150);
    // R7 boundary: exactly 17
    configure(3, 17, "R7");
    run(500);
    // R9: lowered frame length while slot beyond new end
    configure(2, 40, "R6");
    cnt = 0;
    while (!(slot >= 30 && rise_stb) && cnt < 2000) begin @(posedge clk); #1.5; cnt++; end
    configure(2, 17, "R9");
    cnt = 0;
    @(posedge clk); #1.5;
    while (!rise_stb && cnt < 100) begin @(posedge clk); #1.5; cnt++; end
    check("R9 wrap sync", sync, 1);
    check("R9 wrap slot", slot, 0);
    run(200);
    // R9: lowered divider mid half-period
    configure(9, 20, "R6");
    cnt = 0;
    while (!rise_stb && cnt < 100) begin @(posedge clk); #1.5; cnt++; end
    run(6);
    configure(2, 20, "R9");
    @(posedge clk); #1.5;
    check("R9 divider lowered", fall_stb, 1);
    run(300);
    // R1: disable mid-run, then re-enable
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R1 drop sclk", sclk, 0);
    check("R1 drop sync", sync, 0);
    check("R1 drop slot", slot, 0);
    configure(1, 18, "R5");
    en = 1'b1;
    @(negedge clk);
    check("R5 sync after re-enable", sync, 1);
    run(300);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule